// File: doc/BRIEF.md
# ADC control register sequencer

This block sits between a byte-wide special-function-register bus and an on-chip analog-to-digital converter. Software programs one control byte that powers the converter, picks one of eight analog inputs, starts a conversion and watches its completion. The block turns those register writes into a one-cycle start pulse and a latched channel number for the converter. It captures the 16-bit result when the converter reports done, and it raises an interrupt request.

After the converter is enabled, a calibration lockout of `CAL_CYCLES` clocks must pass before any start is honoured. This parameter stands for the converter's power-up calibration time, about 16 ms at the system clock. The completion status bit and the interrupt flag follow a clear-by-software discipline. The flag is set by hardware only when the status bit rises. Writing 0 to either bit clears it, and writing 1 to either bit does nothing.

Top module: `adc_sfr_seq`

## Requirements
- R1: After reset the control byte (address 0x97) reads 0x00, the result reads 0x0000 both through its bytes (low byte at 0x95, high byte at 0x96) and on `result_word`, and `irq` and `cnv_power` are 0.
- R2: The control byte holds, from bit 7 down: interrupt flag, interrupt enable, converter enable, a 3-bit channel field in bits 4..2, start in bit 1, completion status in bit 0. Unmapped addresses read 0x00.
- R3: `cnv_power` follows the enable bit. A start written while enable is 0 produces no `cnv_start` pulse.
- R4: After enable goes from 0 to 1, starts are ignored until `CAL_CYCLES` clocks have elapsed. A start written afterwards is accepted.
- R5: An accepted start drives `cnv_start` high for exactly one cycle. The start bit reads 1 in that cycle and 0 afterwards, and the status bit is cleared.
- R6: The channel field is latched onto `cnv_chan` when a start is accepted. Later writes to the channel field leave `cnv_chan` unchanged until the next accepted start.
- R7: A `cnv_done` pulse during a conversion sets the status bit and loads `cnv_data` into the result register. The result changes at no other time.
- R8: The interrupt flag is set when the status bit goes from 0 to 1. `irq` is 1 exactly when both the flag and the interrupt enable are 1.
- R9: Writing 0 to the status bit or the flag clears it. Writing 1 to either has no effect. Hardware never clears the flag.
- R10: Writing enable as 0 aborts a conversion in progress, so a later `cnv_done` changes neither status nor result. Re-enabling starts a full new calibration lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wr | input | 1 | Write strobe, one cycle per write |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| result_word | output | 16 | Current result register |
| cnv_power | output | 1 | Converter power/enable |
| cnv_start | output | 1 | One-cycle conversion start pulse |
| cnv_chan | output | 3 | Channel latched at start |
| cnv_done | input | 1 | One-cycle conversion complete pulse |
| cnv_data | input | 16 | Conversion result, valid with `cnv_done` |

## Verification
The assertions assume that `cnv_done` is a single-cycle pulse that follows a start, and that every register write is a one-cycle strobe. The result-stability and flag-hold properties rely on both assumptions. The converter stub in the bench answers each start with exactly one done pulse after a random latency of 3 to 7 cycles. That latency is always far shorter than the calibration window, so a stale done left over from an aborted conversion can never coincide with a new start. All writes go through a task that raises `sfr_wr` for one clock only.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned RES_W   = 16;
    localparam int unsigned CHAN_W  = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 8'h97;
    localparam logic [ADDR_W-1:0] ADDR_RES_LO = 8'h95;
    localparam logic [ADDR_W-1:0] ADDR_RES_HI = 8'h96;

    // Control byte layout, bit 7 first.
    typedef struct packed {
        logic              flag;
        logic              ie;
        logic              en;
        logic [CHAN_W-1:0] chan;
        logic              start;
        logic              status;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '0;

    function automatic logic [DATA_W-1:0] res_byte(input logic [RES_W-1:0] r,
                                                   input logic hi);
        return hi ? r[RES_W-1:DATA_W] : r[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/adc_cal_timer.sv
module adc_cal_timer #(
    parameter int unsigned CAL_CYCLES = 640000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic ready
);
    localparam int unsigned CNT_W = $clog2(CAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CAL_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready = en && (cnt_q == CNT_MAX);

    // R4
    cal_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> !ready);

    // R10
    cal_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));

endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cal_ready,
    input  logic              done,
    output ctrl_t             ctrl,
    output logic [CHAN_W-1:0] chan_lat,
    output logic              done_ok
);
    ctrl_t             ctrl_q, ctrl_d, w;
    logic              busy_q, busy_d;
    logic [CHAN_W-1:0] chan_q;
    logic              start_req, abort;

    assign w         = ctrl_t'(wdata);
    assign start_req = wr_ctrl && w.start && w.en && ctrl_q.en && cal_ready;
    assign abort     = wr_ctrl && !w.en;
    assign done_ok   = done && busy_q && !abort;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.start = start_req;
        if (wr_ctrl) begin
            ctrl_d.ie   = w.ie;
            ctrl_d.en   = w.en;
            ctrl_d.chan = w.chan;
            if (!w.status) ctrl_d.status = 1'b0;
            if (!w.flag)   ctrl_d.flag   = 1'b0;
        end
        if (done_ok)   ctrl_d.status = 1'b1;
        if (start_req) ctrl_d.status = 1'b0;
        if (!ctrl_q.status && ctrl_d.status) ctrl_d.flag = 1'b1;

        busy_d = busy_q;
        if (done_ok)   busy_d = 1'b0;
        if (start_req) busy_d = 1'b1;
        if (abort)     busy_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            busy_q <= 1'b0;
            chan_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            busy_q <= busy_d;
            if (start_req) chan_q <= w.chan;
        end
    end

    assign ctrl     = ctrl_q;
    assign chan_lat = chan_q;

    // R5
    start_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.start |=> !ctrl_q.start);

    // R5
    start_clears_status_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.start |-> !ctrl_q.status);

    // R8
    flag_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.status) |-> ctrl_q.flag);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flag && !(wr_ctrl && !w.flag)) |=> ctrl_q.flag);

    // R6
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !start_req) |=> $stable(chan_q));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |-> !busy_q);

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RES_W-1:0] din,
    output logic [RES_W-1:0] q
);
    logic [RES_W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)       q_r <= '0;
        else if (load) q_r <= din;
    end

    assign q = q_r;

    // R7
    result_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q_r));

endmodule

// File: rtl/adc_sfr_seq.sv
module adc_sfr_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned CAL_CYCLES = 640000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  sfr_addr,
    input  logic        sfr_wr,
    input  logic [7:0]  sfr_wdata,
    output logic [7:0]  sfr_rdata,
    output logic        irq,
    output logic [15:0] result_word,
    output logic        cnv_power,
    output logic        cnv_start,
    output logic [2:0]  cnv_chan,
    input  logic        cnv_done,
    input  logic [15:0] cnv_data
);
    ctrl_t      ctrl;
    logic       cal_ready, done_ok, wr_ctrl;
    logic [RES_W-1:0] res;

    assign wr_ctrl = sfr_wr && (sfr_addr == ADDR_CTRL);

    adc_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
        .clk   (clk),
        .rst   (rst),
        .en    (ctrl.en),
        .ready (cal_ready)
    );

    adc_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wdata     (sfr_wdata),
        .cal_ready (cal_ready),
        .done      (cnv_done),
        .ctrl      (ctrl),
        .chan_lat  (cnv_chan),
        .done_ok   (done_ok)
    );

    adc_result_reg u_res (
        .clk  (clk),
        .rst  (rst),
        .load (done_ok),
        .din  (cnv_data),
        .q    (res)
    );

    always_comb begin
        unique case (sfr_addr)
            ADDR_CTRL:   sfr_rdata = ctrl;
            ADDR_RES_LO: sfr_rdata = res_byte(res, 1'b0);
            ADDR_RES_HI: sfr_rdata = res_byte(res, 1'b1);
            default:     sfr_rdata = '0;
        endcase
    end

    assign irq         = ctrl.flag && ctrl.ie;
    assign result_word = res;
    assign cnv_power   = ctrl.en;
    assign cnv_start   = ctrl.start;

    // R3
    start_powered_chk: assert property (@(posedge clk) disable iff (rst)
        cnv_start |-> cnv_power);

    // R8
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl.ie) |-> !irq);

endmodule

// File: tb/adc_sfr_seq_tb.sv
module adc_sfr_seq_tb;
    localparam int CAL = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        irq, cnv_power, cnv_start, cnv_done;
    logic [2:0]  cnv_chan;
    logic [15:0] result_word, cnv_data;

    int n_chk = 0, n_fail = 0, start_cnt = 0;
    int pend = 0, seq = 0, last_seq = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_sfr_seq #(.CAL_CYCLES(CAL)) u_dut (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq(irq),
        .result_word(result_word), .cnv_power(cnv_power),
        .cnv_start(cnv_start), .cnv_chan(cnv_chan),
        .cnv_done(cnv_done), .cnv_data(cnv_data)
    );

    function automatic logic [15:0] mk(input logic [2:0] ch, input int s);
        logic [7:0] sb = 8'(s);
        return {ch, sb[4:0], sb ^ 8'hA5};
    endfunction

    function automatic logic [7:0] cbyte(input bit fl, ie, en,
                                         input logic [2:0] ch, input bit st, stat);
        return {fl, ie, en, ch, st, stat};
    endfunction

    // Converter stub and start-pulse monitor.
    initial begin
        cnv_done = 1'b0;
        cnv_data = '0;
        forever begin
            @(posedge clk);
            cnv_done <= 1'b0;
            if (rst) pend = 0;
            else begin
                if (cnv_start) start_cnt++;
                if (pend > 0) begin
                    pend--;
                    if (pend == 0) begin
                        cnv_done <= 1'b1;
                        cnv_data <= mk(cnv_chan, seq);
                        last_seq = seq;
                        seq++;
                    end
                end
                if (cnv_start) pend = 3 + int'($urandom % 5);
            end
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wait_done(output bit ok);
        logic [7:0] c;
        ok = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            rd(8'h97, c);
            if (c[0]) begin ok = 1; break; end
        end
    endtask

    task automatic check_result(input string req, input logic [2:0] ch);
        logic [7:0] lo, hi;
        logic [15:0] e;
        e = mk(ch, last_seq);
        rd(8'h95, lo);
        rd(8'h96, hi);
        chk(req, {hi, lo}, e);
        chk(req, result_word, e);
    endtask

    initial begin
        logic [7:0] c;
        logic [15:0] keep;
        int sc;
        bit ok;
        void'($urandom(32'hC0FFEE));
        tick(3);
        rst = 1'b0;
        tick();

        // R1 reset state
        rd(8'h97, c);  chk("R1 ctrl", c, 8'h00);
        chk("R1 result", result_word, 16'h0);
        chk("R1 irq/power", {irq, cnv_power}, 2'b00);
        // R2 unmapped address
        rd(8'h10, c);  chk("R2 unmapped", c, 8'h00);

        // R3 start while disabled ignored
        sc = start_cnt;
        wr(8'h97, 8'h02);
        tick(2);
        chk("R3 no start when off", start_cnt, sc);
        rd(8'h97, c);  chk("R3 ctrl stays 0", c, 8'h00);

        // R3/R4 enable, then early start ignored
        wr(8'h97, 8'h20);
        chk("R3 power on", cnv_power, 1'b1);
        tick(CAL / 2);
        wr(8'h97, 8'h22);
        tick(2);
        chk("R4 early start ignored", start_cnt, sc);
        rd(8'h97, c);  chk("R4 no status", c, 8'h20);

        // R4/R5/R6 accepted start after calibration
        tick(CAL);
        wr(8'h97, cbyte(0, 1, 1, 3'd3, 1, 0));
        chk("R5 start pulse", cnv_start, 1'b1);
        chk("R6 chan", cnv_chan, 3'd3);
        rd(8'h97, c);  chk("R5 start bit reads 1", c, cbyte(0, 1, 1, 3'd3, 1, 0));
        // R6 change channel while busy
        wr(8'h97, cbyte(0, 1, 1, 3'd6, 0, 0));
        chk("R5 start self-clears", cnv_start, 1'b0);
        rd(8'h97, c);  chk("R5 start bit 0", c[1], 1'b0);
        chk("R6 chan held", cnv_chan, 3'd3);
        wait_done(ok);
        chk("R7 done seen", ok, 1'b1);
        check_result("R7 R6 result", 3'd3);
        rd(8'h97, c);  chk("R8 flag set", c, cbyte(1, 1, 1, 3'd6, 0, 1));
        chk("R8 irq", irq, 1'b1);

        // R9 clear status keeping flag: flag persists
        wr(8'h97, cbyte(1, 1, 1, 3'd6, 0, 0));
        rd(8'h97, c);  chk("R9 status cleared flag kept", c, cbyte(1, 1, 1, 3'd6, 0, 0));
        tick(5);
        chk("R9 hw never clears flag", irq, 1'b1);
        // R8 irq needs enable
        wr(8'h97, cbyte(1, 0, 1, 3'd6, 0, 0));
        chk("R8 irq off without ie", irq, 1'b0);
        // R9 clear flag, then writing 1s has no effect
        wr(8'h97, cbyte(0, 1, 1, 3'd6, 0, 0));
        chk("R9 flag cleared", irq, 1'b0);
        wr(8'h97, cbyte(1, 1, 1, 3'd6, 0, 1));
        rd(8'h97, c);  chk("R9 writing 1 ignored", c, cbyte(0, 1, 1, 3'd6, 0, 0));
        chk("R9 irq still 0", irq, 1'b0);

        // R5 start clears a set status
        wr(8'h97, cbyte(0, 0, 1, 3'd1, 1, 0));
        wait_done(ok);
        check_result("R7 result ch1", 3'd1);
        wr(8'h97, cbyte(1, 0, 1, 3'd2, 1, 1));
        rd(8'h97, c);  chk("R5 start clears status", c[0], 1'b0);
        wait_done(ok);
        check_result("R7 result ch2", 3'd2);

        // R10 abort: disable during conversion
        keep = result_word;
        wr(8'h97, cbyte(0, 0, 1, 3'd7, 1, 0));
        wr(8'h97, 8'h00);
        chk("R10 power off", cnv_power, 1'b0);
        tick(12);
        rd(8'h97, c);  chk("R10 no status after abort", c, 8'h00);
        chk("R10 result kept", result_word, keep);
        // R10 re-enable restarts calibration
        sc = start_cnt;
        wr(8'h97, 8'h20);
        tick(CAL - 6);
        wr(8'h97, 8'h22);
        tick(2);
        chk("R10 new calibration", start_cnt, sc);
        tick(CAL);

        // Random conversions
        for (int i = 0; i < 30; i++) begin
            logic [2:0] ch = 3'($urandom % 8);
            bit ie = 1'($urandom % 2);
            wr(8'h97, cbyte(0, ie, 1, ch, 1, 0));
            chk("R6 rand chan", cnv_chan, ch);
            if ($urandom % 2) wr(8'h97, cbyte(0, ie, 1, 3'($urandom % 8), 0, 0));
            wait_done(ok);
            chk("R7 rand done", ok, 1'b1);
            check_result("R7 rand result", ch);
            chk("R8 rand irq", irq, ie);
            wr(8'h97, cbyte(0, ie, 1, ch, 0, 0));
            chk("R9 rand clear", irq, 1'b0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule